// File: doc/BRIEF.md
# Write-Snooping Page-Table Packetizer

This block sits beside a host memory bus and watches ordinary store transactions. Each snooped byte address is split into a local page number (upper bits) and an in-page byte offset (lower bits). The page number indexes a small per-page mapping table directly. If the page is mapped out in automatic-update mode, the block forms an outgoing packet right away. The packet holds the destination node and destination page taken from the table entry, the original offset and the stored data word. The packet goes into an outgoing FIFO, and the network side drains it from the head with a valid/ready handshake. Stores to pages that are unmapped or in deliberate-update mode pass by with no effect.

The receive direction takes packets that target a local page and an offset into an incoming FIFO. At the FIFO head, the block looks up the target page in the same table. If the page is mapped in, the block issues a single-cycle memory write. If it is not, the block drops the packet and increments an error counter. The table is programmed through a one-cycle write port. Snooping never changes a store. The only time the block pushes back on the bus is when a store to an automatic-update page finds the outgoing FIFO full.

Top module: `snoop_page_packetizer`

## Requirements
- R1: After reset, every table entry has out-mode 0 (unmapped) and mapped-in 0. At that point tx_valid, mem_we, snp_stall and drop_cnt are 0, rx_ready is 1, and a snooped store produces no packet.
- R2: A store snooped to a page whose out-mode is 1 (automatic update) is accepted at the clock edge where snp_valid is high and snp_stall is low. From the next cycle the outgoing head shows that packet: tx_node and tx_dpage come from the entry, tx_off is snp_addr[11:0] and tx_data is snp_data. The page number is snp_addr[15:12].
- R3: A store snooped to a page with out-mode 0 (unmapped), 2 (deliberate update) or 3 (reserved) produces no packet.
- R4: Outgoing packets leave in snoop order. A packet leaves at each edge where tx_valid and tx_ready are both high. While tx_ready is low, the head packet stays on the tx_* ports unchanged.
- R5: With 8 packets pending, a store to an automatic-update page raises snp_stall in the same cycle and is not captured. When the bus presents the store again after a packet has left, it is accepted.
- R6: snp_stall is high only while snp_valid is high and the addressed page is in automatic-update mode. Stores to other pages are never stalled, even when the outgoing FIFO is full.
- R7: An incoming packet accepted while rx_ready is high, aimed at a page whose mapped-in bit is 1, produces one cycle of mem_we. This happens one cycle after acceptance, with mem_addr = {rx_page, rx_off} and mem_data = rx_data.
- R8: An incoming packet aimed at a page whose mapped-in bit is 0 produces no mem_we and increments drop_cnt by one, in the same cycle a write would have occurred.
- R9: Incoming packets accepted on consecutive cycles produce memory writes on consecutive cycles, in arrival order.
- R10: A table write via cfg_we takes effect for lookups from the cycle after it. A store snooped in the same cycle as the table write still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_page | input | 4 | Local page index being programmed |
| cfg_out_mode | input | 2 | Out-mode: 0 unmapped, 1 automatic, 2 deliberate, 3 reserved |
| cfg_in_en | input | 1 | Mapped-in bit for receive |
| cfg_node | input | 4 | Destination node for the page |
| cfg_dpage | input | 8 | Destination physical page number |
| snp_valid | input | 1 | Snooped store present on the bus |
| snp_addr | input | 16 | Snooped store byte address |
| snp_data | input | 32 | Snooped store data |
| snp_stall | output | 1 | Backpressure: hold the snooped store |
| tx_valid | output | 1 | Outgoing head packet valid |
| tx_ready | input | 1 | Network accepts the head packet |
| tx_node | output | 4 | Head packet destination node |
| tx_dpage | output | 8 | Head packet destination page |
| tx_off | output | 12 | Head packet in-page offset |
| tx_data | output | 32 | Head packet data word |
| rx_valid | input | 1 | Incoming packet present |
| rx_ready | output | 1 | Incoming FIFO has room |
| rx_page | input | 4 | Incoming target local page |
| rx_off | input | 12 | Incoming in-page offset |
| rx_data | input | 32 | Incoming data word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| drop_cnt | output | 8 | Count of dropped incoming packets |

## Verification
A corrupted table entry shows up in the header fields of the first packet that is snooped to that page, one cycle after the store. On receive, the same fault shows as a missing write or a wrongly advanced drop_cnt, one cycle after the packet is accepted. A wrong FIFO pointer or count shows as reordered or duplicated packets at the tx head. It can also show as snp_stall rising too early or too late around the eighth pending packet. The sweep therefore programs all sixteen pages with arithmetically derived entries and stores to each of them. It fills the outgoing FIFO exactly to its limit and sends one incoming packet to every page.

// File: rtl/pgsnp_pkg.sv
package pgsnp_pkg;
   typedef enum logic [1:0] {
      OUT_NONE  = 2'd0,
      OUT_AUTO  = 2'd1,
      OUT_DELIB = 2'd2,
      OUT_RSVD  = 2'd3
   } out_mode_e;
endpackage

// File: rtl/pgsnp_fifo.sv
module pgsnp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   generate
      if (DEPTH < 2) begin : g_depth_chk
         $error("pgsnp_fifo: DEPTH must be at least 2");
      end
      if (POW2) begin : g_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/pgsnp_table.sv
module pgsnp_table
   import pgsnp_pkg::*;
#(
   parameter int PAGES   = 16,
   parameter int NODE_W  = 4,
   parameter int DPAGE_W = 8,
   localparam int PG_W   = $clog2(PAGES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PG_W-1:0]    wr_idx,
   input  out_mode_e          wr_mode,
   input  logic               wr_in_en,
   input  logic [NODE_W-1:0]  wr_node,
   input  logic [DPAGE_W-1:0] wr_dpage,
   input  logic [PG_W-1:0]    s_idx,
   output out_mode_e          s_mode,
   output logic [NODE_W-1:0]  s_node,
   output logic [DPAGE_W-1:0] s_dpage,
   input  logic [PG_W-1:0]    r_idx,
   output logic               r_in_en
);
   out_mode_e          mode_arr  [PAGES];
   logic               inen_arr  [PAGES];
   logic [NODE_W-1:0]  node_arr  [PAGES];
   logic [DPAGE_W-1:0] dpage_arr [PAGES];

   generate
      for (genvar i = 0; i < PAGES; i++) begin : g_ent
         out_mode_e          mode_q;
         logic               inen_q;
         logic [NODE_W-1:0]  node_q;
         logic [DPAGE_W-1:0] dpage_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode_q  <= OUT_NONE;
               inen_q  <= 1'b0;
               node_q  <= '0;
               dpage_q <= '0;
            end else if (wr_en && (wr_idx == PG_W'(i))) begin
               mode_q  <= wr_mode;
               inen_q  <= wr_in_en;
               node_q  <= wr_node;
               dpage_q <= wr_dpage;
            end
         end

         assign mode_arr[i]  = mode_q;
         assign inen_arr[i]  = inen_q;
         assign node_arr[i]  = node_q;
         assign dpage_arr[i] = dpage_q;
      end
   endgenerate

   assign s_mode  = mode_arr[s_idx];
   assign s_node  = node_arr[s_idx];
   assign s_dpage = dpage_arr[s_idx];
   assign r_in_en = inen_arr[r_idx];
endmodule

// File: rtl/pgsnp_rx_sink.sv
module pgsnp_rx_sink #(
   parameter int PG_W   = 4,
   parameter int OFF_W  = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    head_vld,
   input  logic [PG_W-1:0]         head_page,
   input  logic [OFF_W-1:0]        head_off,
   input  logic [DATA_W-1:0]       head_data,
   input  logic                    page_in_en,
   output logic                    pop,
   output logic                    mem_we,
   output logic [PG_W+OFF_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]       mem_data,
   output logic [CNT_W-1:0]        drop_cnt
);
   logic accept, reject;

   assign pop    = head_vld;
   assign accept = head_vld && page_in_en;
   assign reject = head_vld && !page_in_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we   <= 1'b0;
         mem_addr <= '0;
         mem_data <= '0;
         drop_cnt <= '0;
      end else begin
         mem_we <= accept;
         if (accept) begin
            mem_addr <= {head_page, head_off};
            mem_data <= head_data;
         end
         if (reject) drop_cnt <= drop_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/snoop_page_packetizer.sv
module snoop_page_packetizer
   import pgsnp_pkg::*;
#(
   parameter int PAGES      = 16,
   parameter int PAGE_BYTES = 4096,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8,
   parameter int NODE_W     = 4,
   parameter int DPAGE_W    = 8,
   parameter int CNT_W      = 8,
   localparam int PG_W      = $clog2(PAGES),
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int ADDR_W    = PG_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [PG_W-1:0]    cfg_page,
   input  logic [1:0]         cfg_out_mode,
   input  logic               cfg_in_en,
   input  logic [NODE_W-1:0]  cfg_node,
   input  logic [DPAGE_W-1:0] cfg_dpage,
   input  logic               snp_valid,
   input  logic [ADDR_W-1:0]  snp_addr,
   input  logic [DATA_W-1:0]  snp_data,
   output logic               snp_stall,
   output logic               tx_valid,
   input  logic               tx_ready,
   output logic [NODE_W-1:0]  tx_node,
   output logic [DPAGE_W-1:0] tx_dpage,
   output logic [OFF_W-1:0]   tx_off,
   output logic [DATA_W-1:0]  tx_data,
   input  logic               rx_valid,
   output logic               rx_ready,
   input  logic [PG_W-1:0]    rx_page,
   input  logic [OFF_W-1:0]   rx_off,
   input  logic [DATA_W-1:0]  rx_data,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_data,
   output logic [CNT_W-1:0]   drop_cnt
);
   localparam int TXW = NODE_W + DPAGE_W + OFF_W + DATA_W;
   localparam int RXW = PG_W + OFF_W + DATA_W;

   generate
      if (PAGES < 2 || (PAGES & (PAGES - 1)) != 0) begin : g_pages_chk
         $error("snoop_page_packetizer: PAGES must be a power of two >= 2");
      end
      if (PAGE_BYTES < 4 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_psize_chk
         $error("snoop_page_packetizer: PAGE_BYTES must be a power of two >= 4");
      end
   endgenerate

   // lookup of the snooped page
   logic [PG_W-1:0]    snp_page;
   logic [OFF_W-1:0]   snp_off;
   out_mode_e          s_mode;
   logic [NODE_W-1:0]  s_node;
   logic [DPAGE_W-1:0] s_dpage;
   logic               auto_hit;
   logic               tx_full, tx_empty;
   logic [TXW-1:0]     tx_head;

   // receive side
   logic [RXW-1:0]     rx_head;
   logic               rx_full, rx_empty, rx_pop;
   logic [PG_W-1:0]    h_page;
   logic [OFF_W-1:0]   h_off;
   logic [DATA_W-1:0]  h_data;
   logic               h_in_en;

   assign snp_page = snp_addr[ADDR_W-1:OFF_W];
   assign snp_off  = snp_addr[OFF_W-1:0];
   assign auto_hit = snp_valid && (s_mode == OUT_AUTO);
   assign snp_stall = auto_hit && tx_full;

   pgsnp_table #(
      .PAGES(PAGES), .NODE_W(NODE_W), .DPAGE_W(DPAGE_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_page), .wr_mode(out_mode_e'(cfg_out_mode)),
      .wr_in_en(cfg_in_en), .wr_node(cfg_node), .wr_dpage(cfg_dpage),
      .s_idx(snp_page), .s_mode(s_mode), .s_node(s_node), .s_dpage(s_dpage),
      .r_idx(h_page), .r_in_en(h_in_en)
   );

   pgsnp_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(auto_hit), .din({s_node, s_dpage, snp_off, snp_data}),
      .pop(tx_ready), .dout(tx_head), .empty(tx_empty), .full(tx_full)
   );

   assign tx_valid = !tx_empty;
   assign {tx_node, tx_dpage, tx_off, tx_data} = tx_head;

   pgsnp_fifo #(.W(RXW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_valid), .din({rx_page, rx_off, rx_data}),
      .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full)
   );

   assign rx_ready = !rx_full;
   assign {h_page, h_off, h_data} = rx_head;

   pgsnp_rx_sink #(
      .PG_W(PG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
   ) u_sink (
      .clk(clk), .rst_n(rst_n),
      .head_vld(!rx_empty), .head_page(h_page), .head_off(h_off),
      .head_data(h_data), .page_in_en(h_in_en),
      .pop(rx_pop), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_data(mem_data), .drop_cnt(drop_cnt)
   );
endmodule

// File: rtl/snoop_page_packetizer_chk.sv
module snoop_page_packetizer_chk #(
   parameter int TXW   = 56,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snp_valid,
   input logic             snp_stall,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [TXW-1:0]   tx_pkt,
   input logic             mem_we,
   input logic [CNT_W-1:0] drop_cnt
);
   // R2: a packet can only appear after a snooped store
   p_pkt_from_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> $past(snp_valid));

   // R4: head held while the network is not ready
   p_head_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_pkt)));

   // R5: stall only when packets are pending
   p_stall_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      snp_stall |-> tx_valid);

   // R6: stall never without a store on the bus
   p_stall_needs_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_stall |-> snp_valid);

   // R8: a drop and a write never happen for the same cycle
   p_drop_excl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt) |-> !mem_we);

   // R8: drop counter advances by exactly one
   p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt) |-> (drop_cnt == $past(drop_cnt) + 1'b1));
endmodule

bind snoop_page_packetizer snoop_page_packetizer_chk #(
   .TXW(NODE_W + DPAGE_W + OFF_W + DATA_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_stall(snp_stall),
   .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_pkt({tx_node, tx_dpage, tx_off, tx_data}),
   .mem_we(mem_we), .drop_cnt(drop_cnt)
);

// File: tb/snoop_page_packetizer_bench.sv
module snoop_page_packetizer_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_in_en;
   logic [3:0]  cfg_page, cfg_node;
   logic [1:0]  cfg_out_mode;
   logic [7:0]  cfg_dpage;
   logic        snp_valid, snp_stall;
   logic [15:0] snp_addr;
   logic [31:0] snp_data;
   logic        tx_valid, tx_ready;
   logic [3:0]  tx_node;
   logic [7:0]  tx_dpage;
   logic [11:0] tx_off;
   logic [31:0] tx_data;
   logic        rx_valid, rx_ready;
   logic [3:0]  rx_page;
   logic [11:0] rx_off;
   logic [31:0] rx_data;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_data;
   logic [7:0]  drop_cnt;

   int nchk = 0;
   int nbad = 0;
   bit done = 0;
   int exp_drop = 0;

   always #4 clk = ~clk;

   snoop_page_packetizer u_snoop_page_packetizer (.*);

   function automatic int ref_mode(int p);  return p % 3; endfunction
   function automatic bit ref_inen(int p);  return bit'(p % 2); endfunction
   function automatic logic [3:0] ref_node(int p);  return 4'((p * 5 + 3) % 16); endfunction
   function automatic logic [7:0] ref_dpage(int p); return 8'((p * 7 + 1) % 256); endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] pkt_now();
      return {8'h0, tx_node, tx_dpage, tx_off, tx_data};
   endfunction

   function automatic logic [63:0] pkt_ref(logic [3:0] n, logic [7:0] d, logic [11:0] o, logic [31:0] w);
      return {8'h0, n, d, o, w};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cfg_we = 0; cfg_in_en = 0; cfg_page = 0; cfg_node = 0;
      cfg_out_mode = 0; cfg_dpage = 0; snp_valid = 0; snp_addr = 0;
      snp_data = 0; tx_ready = 0; rx_valid = 0; rx_page = 0; rx_off = 0;
      rx_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1;
      chk(tx_valid == 0, "R1 tx_valid", 64'(tx_valid), 0);
      chk(mem_we == 0, "R1 mem_we", 64'(mem_we), 0);
      chk(drop_cnt == 0, "R1 drop_cnt", 64'(drop_cnt), 0);
      chk(snp_stall == 0, "R1 snp_stall", 64'(snp_stall), 0);
      chk(rx_ready == 1, "R1 rx_ready", 64'(rx_ready), 1);
      // R1: unprogrammed table ignores stores
      @(negedge clk); snp_valid = 1; snp_addr = {4'd1, 12'h010}; snp_data = 32'h1234;
      @(posedge clk); #1;
      chk(tx_valid == 0, "R1 no packet after reset", 64'(tx_valid), 0);
      @(negedge clk); snp_valid = 0;

      // program the table
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         cfg_we = 1; cfg_page = 4'(p); cfg_out_mode = 2'(ref_mode(p));
         cfg_in_en = ref_inen(p); cfg_node = ref_node(p); cfg_dpage = ref_dpage(p);
      end
      @(negedge clk); cfg_we = 0; tx_ready = 1;

      // R2 / R3 sweep over every page
      for (int p = 0; p < 16; p++) begin
         logic [11:0] off;
         logic [31:0] dat;
         off = 12'((p * 273) % 4096);
         dat = 32'hA000_0000 + 32'(p);
         @(negedge clk); snp_valid = 1; snp_addr = {4'(p), off}; snp_data = dat;
         #1 chk(snp_stall == 0, "R6 no stall while empty", 64'(snp_stall), 0);
         @(posedge clk); #1;
         if (ref_mode(p) == 1) begin
            chk(tx_valid == 1, "R2 packet present", 64'(tx_valid), 1);
            chk(pkt_now() == pkt_ref(ref_node(p), ref_dpage(p), off, dat),
                "R2 packet fields", pkt_now(), pkt_ref(ref_node(p), ref_dpage(p), off, dat));
         end else begin
            chk(tx_valid == 0, "R3 ignored page", 64'(tx_valid), 0);
         end
         @(negedge clk); snp_valid = 0;
         @(posedge clk); #1;
         chk(tx_valid == 0, "R4 packet left", 64'(tx_valid), 0);
      end

      // R5 fill outgoing FIFO with stores to page 4
      @(negedge clk); tx_ready = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); snp_valid = 1; snp_addr = {4'd4, 12'(k * 16 + 3)};
         snp_data = 32'hC0DE_0000 + 32'(k);
         #1 chk(snp_stall == 0, "R5 no stall before full", 64'(snp_stall), 0);
         @(posedge clk);
      end
      @(negedge clk); snp_addr = {4'd4, 12'(8 * 16 + 3)}; snp_data = 32'hC0DE_0008;
      #1 chk(snp_stall == 1, "R5 stall when full", 64'(snp_stall), 1);
      snp_addr = {4'd0, 12'h020};
      #1 chk(snp_stall == 0, "R6 unmapped not stalled", 64'(snp_stall), 0);
      snp_addr = {4'd2, 12'h020};
      #1 chk(snp_stall == 0, "R6 deliberate not stalled", 64'(snp_stall), 0);
      snp_valid = 0;
      repeat (2) @(posedge clk);
      #1 chk(pkt_now() == pkt_ref(4'd7, 8'd29, 12'd3, 32'hC0DE_0000),
             "R4 head held", pkt_now(), pkt_ref(4'd7, 8'd29, 12'd3, 32'hC0DE_0000));
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); tx_ready = 1;
         #1;
         chk(tx_valid == 1, "R4 drain valid", 64'(tx_valid), 1);
         chk(pkt_now() == pkt_ref(4'd7, 8'd29, 12'(k * 16 + 3), 32'hC0DE_0000 + 32'(k)),
             "R4 drain order", pkt_now(),
             pkt_ref(4'd7, 8'd29, 12'(k * 16 + 3), 32'hC0DE_0000 + 32'(k)));
         @(posedge clk);
      end
      @(negedge clk); #1 chk(tx_valid == 0, "R4 drained", 64'(tx_valid), 0);
      snp_valid = 1; snp_addr = {4'd4, 12'(8 * 16 + 3)}; snp_data = 32'hC0DE_0008;
      #1 chk(snp_stall == 0, "R5 retry not stalled", 64'(snp_stall), 0);
      @(posedge clk); #1;
      chk(pkt_now() == pkt_ref(4'd7, 8'd29, 12'(8 * 16 + 3), 32'hC0DE_0008),
          "R5 retried store sent", pkt_now(), pkt_ref(4'd7, 8'd29, 12'(8 * 16 + 3), 32'hC0DE_0008));
      @(negedge clk); snp_valid = 0;

      // R7 / R8 receive sweep
      for (int p = 0; p < 16; p++) begin
         @(negedge clk); rx_valid = 1; rx_page = 4'(p); rx_off = 12'(p * 17);
         rx_data = 32'hD000_0000 + 32'(p);
         #1 chk(rx_ready == 1, "R7 rx_ready", 64'(rx_ready), 1);
         @(posedge clk);
         @(negedge clk); rx_valid = 0;
         @(posedge clk); #1;
         if (ref_inen(p)) begin
            chk(mem_we == 1, "R7 write issued", 64'(mem_we), 1);
            chk({mem_addr, mem_data} == {4'(p), 12'(p * 17), 32'hD000_0000 + 32'(p)},
                "R7 write addr/data", {16'h0, mem_addr, mem_data},
                {16'h0, 4'(p), 12'(p * 17), 32'hD000_0000 + 32'(p)});
         end else begin
            exp_drop++;
            chk(mem_we == 0, "R8 no write", 64'(mem_we), 0);
         end
         chk(drop_cnt == 8'(exp_drop), "R8 drop count", 64'(drop_cnt), 64'(exp_drop));
      end

      // R9 back-to-back receive
      @(negedge clk); rx_valid = 1; rx_page = 4'd1; rx_off = 12'h101; rx_data = 32'hE1;
      @(posedge clk);
      @(negedge clk); rx_page = 4'd3; rx_off = 12'h303; rx_data = 32'hE3;
      @(posedge clk); #1;
      chk(mem_we && mem_addr == 16'h1101 && mem_data == 32'hE1, "R9 first write",
          {15'h0, mem_we, mem_addr, mem_data}, {15'h0, 1'b1, 16'h1101, 32'hE1});
      @(negedge clk); rx_page = 4'd5; rx_off = 12'h505; rx_data = 32'hE5;
      @(posedge clk); #1;
      chk(mem_we && mem_addr == 16'h3303 && mem_data == 32'hE3, "R9 second write",
          {15'h0, mem_we, mem_addr, mem_data}, {15'h0, 1'b1, 16'h3303, 32'hE3});
      @(negedge clk); rx_valid = 0;
      @(posedge clk); #1;
      chk(mem_we && mem_addr == 16'h5505 && mem_data == 32'hE5, "R9 third write",
          {15'h0, mem_we, mem_addr, mem_data}, {15'h0, 1'b1, 16'h5505, 32'hE5});

      // R10 reprogram page 0
      @(negedge clk);
      cfg_we = 1; cfg_page = 4'd0; cfg_out_mode = 2'd1; cfg_in_en = 1;
      cfg_node = 4'd9; cfg_dpage = 8'h5A;
      snp_valid = 1; snp_addr = {4'd0, 12'h0AB}; snp_data = 32'hF00D;
      @(posedge clk); #1;
      chk(tx_valid == 0, "R10 same-cycle old entry", 64'(tx_valid), 0);
      @(negedge clk); cfg_we = 0;
      @(posedge clk); #1;
      chk(tx_valid && pkt_now() == pkt_ref(4'd9, 8'h5A, 12'h0AB, 32'hF00D),
          "R10 new entry used", pkt_now(), pkt_ref(4'd9, 8'h5A, 12'h0AB, 32'hF00D));
      @(negedge clk); snp_valid = 0;
      rx_valid = 1; rx_page = 4'd0; rx_off = 12'h00C; rx_data = 32'hBEEF;
      @(posedge clk);
      @(negedge clk); rx_valid = 0;
      @(posedge clk); #1;
      chk(mem_we == 1 && drop_cnt == 8'(exp_drop), "R10 page now mapped in",
          {55'h0, mem_we, drop_cnt}, {55'h0, 1'b1, 8'(exp_drop)});

      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule